// File: doc/BRIEF.md
# Serial-Programmed Wiper Position Controller

This block is the digital control core of a 128-tap programmable resistor. A three-wire serial port (active-low select, serial clock, serial data) shifts a 7-bit code into a shift register. When the select line goes high again, the code moves into a wiper latch. The latch is decoded into a registered one-hot tap select and two end-switch controls that drive the analog ladder.

An open-drain serial output repeats the bits that leave the shift register, so several devices can be chained on one select line. An active-low reset returns the wiper to midscale. An active-low shutdown isolates the ladder's A end and ties the wiper to B without losing the stored code. The code can still be written while shutdown is held, so a preset can be loaded before the ladder is enabled.

All serial pins are sampled by a fast system clock through two-flop synchronizers. The system clock must run at least four times faster than the serial clock.

Top module: `wiper_ctrl`

## Requirements
- R1: Each data bit is captured on a synchronized rising edge of `sclk` while `cs_n` is low, and the first bit sent becomes the most significant bit of the 7-bit code.
- R2: The wiper code changes only when a rising edge of `cs_n` is detected, and it then takes the shift register contents.
- R3: Rising edges of `sclk` while `cs_n` is high change neither the shift register nor the wiper code.
- R4: When more than 7 bits arrive in one select window, only the last 7 are kept.
- R5: On each captured clock edge, the serial output latch takes the bit leaving the shift register. That bit entered seven captured edges earlier. `sdo_pull_low` is 1 (drive low) when the latch holds 0 and is 0 (released) when it holds 1.
- R6: While `rst_n` is low, and after it is released, the code is 0x40 (only `tap_sel[64]` set) and the serial output latch holds 1, so `sdo_pull_low` is 0.
- R7: While shutdown is active, `tap_sel` is all zeros, `sw_a_closed` is 0, `sw_b_closed` is 1 and `sdo_pull_low` is 0.
- R8: When shutdown is released, the tap select shows the code stored before shutdown.
- R9: A word loaded while shutdown is active becomes the wiper setting once shutdown is released.
- R10: Outside shutdown, exactly one bit of `tap_sel` is set, at the index equal to the code. Code 0x00 sets bit 0 and code 0x7F sets bit 127.
- R11: After `cs_n` goes high, `tap_sel` keeps its old value through the first three rising system clock edges and shows the new code after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset to midscale |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, MSB first |
| shdn_n | input | 1 | Shutdown, active low |
| sdo_pull_low | output | 1 | Open-drain serial output; 1 drives the line low |
| tap_sel | output | 128 | One-hot tap select |
| sw_a_closed | output | 1 | A-end switch control, 1 = closed |
| sw_b_closed | output | 1 | Wiper-to-B short control, 1 = closed |

## Verification
The bench targets words longer than seven bits. A design that kept the leading bits instead of the trailing ones would latch the wrong code. It also toggles the serial clock while select is high, which a design that did not gate on select would shift into the latch. Shutdown is tested with a write made during shutdown and with a plain release. A design that cleared the code on shutdown, or that blocked writes during it, would come back at the wrong tap. Two further checks cover the exact cycle in which the tap select changes after select rises, and the bit shown on the serial output after a 14-bit chained frame. A single-cycle slip would show up in either.

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int CODE_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      sclk,
  input  logic                      sdi,
  input  logic                      shdn_n,
  output logic                      sdo_pull_low,
  output logic [(1<<CODE_W)-1:0]    tap_sel,
  output logic                      sw_a_closed,
  output logic                      sw_b_closed
);
  localparam int TAPS = 1 << CODE_W;
  localparam logic [CODE_W-1:0] MID = CODE_W'(TAPS / 2);

  logic [2:0] cs_p, ck_p;
  logic [1:0] di_p, sd_p;
  logic [CODE_W-1:0] shreg, code;
  logic sdo_q, shut_q;

  wire ck_rise = ck_p[1] & ~ck_p[2];
  wire cs_rise = cs_p[1] & ~cs_p[2];
  wire sel     = ~cs_p[1];
  wire sd_on   = ~sd_p[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p <= '1;
      ck_p <= '0;
      di_p <= '0;
      sd_p <= '1;
    end else begin
      cs_p <= {cs_p[1:0], cs_n};
      ck_p <= {ck_p[1:0], sclk};
      di_p <= {di_p[0], sdi};
      sd_p <= {sd_p[0], shdn_n};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      sdo_q <= 1'b1;
    end else if (ck_rise && sel) begin
      shreg <= {shreg[CODE_W-2:0], di_p[1]};
      sdo_q <= shreg[CODE_W-1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       code <= MID;
    else if (cs_rise) code <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tap_sel <= TAPS'(1) << MID;
      shut_q  <= 1'b0;
    end else begin
      tap_sel <= sd_on ? '0 : (TAPS'(1) << code);
      shut_q  <= sd_on;
    end

  assign sw_a_closed  = ~shut_q;
  assign sw_b_closed  = shut_q;
  assign sdo_pull_low = ~sdo_q & ~shut_q;

  // R10
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_on |=> $onehot(tap_sel));
  // R7
  shut_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_on |=> (tap_sel == '0 && sw_b_closed && !sw_a_closed && !sdo_pull_low));
  // R3
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(shreg));
  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(code));
  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_rise && sel) |=> (shreg[0] == $past(di_p[1])));
endmodule

// File: tb/wiper_ctrl_bench.sv
module wiper_ctrl_bench;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0, shdn_n = 1;
  logic sdo_pull_low, sw_a_closed, sw_b_closed;
  logic [127:0] tap_sel;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wiper_ctrl u_wiper_ctrl (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .shdn_n(shdn_n), .sdo_pull_low(sdo_pull_low), .tap_sel(tap_sel),
    .sw_a_closed(sw_a_closed), .sw_b_closed(sw_b_closed));

  // reference model: inputs become visible two edges late
  int hist[$];
  int m_sh, m_code, m_tap, m_sdo, m_shut;

  task automatic model_reset();
    hist = {9, 9, 9, 9};
    m_sh = 0; m_code = 64; m_tap = 64; m_sdo = 1; m_shut = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int h2, h3;
      hist.push_front({cs_n, sclk, sdi, shdn_n});
      void'(hist.pop_back());
      h2 = hist[2]; h3 = hist[3];
      m_shut = (h2 & 1) ? 0 : 1;
      m_tap  = m_shut ? -1 : m_code;
      if (((h2 >> 2) & 1) && !((h3 >> 2) & 1) && !((h2 >> 3) & 1)) begin
        m_sdo = (m_sh >> 6) & 1;
        m_sh  = ((m_sh << 1) | ((h2 >> 1) & 1)) & 127;
      end
      if (((h2 >> 3) & 1) && !((h3 >> 3) & 1)) m_code = m_sh;
    end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] hot(int i);
    return (i < 0) ? 128'd0 : (128'd1 << i);
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk("R10 tap_sel vs model", tap_sel, hot(m_tap));
      chk("R7 sw_a vs model", 128'(sw_a_closed), 128'(!m_shut));
      chk("R7 sw_b vs model", 128'(sw_b_closed), 128'(m_shut));
      chk("R5 sdo vs model", 128'(sdo_pull_low), 128'(!m_sdo && !m_shut));
    end
  end

  task automatic send(int word, int n);
    @(negedge clk) cs_n = 0;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = (word >> i) & 1;
      repeat (2) @(negedge clk);
      sclk = 1;
      repeat (2) @(negedge clk);
      sclk = 0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic idle_clocks();
    for (int i = 0; i < 6; i++) begin
      sdi = i[0];
      repeat (2) @(negedge clk); sclk = 1;
      repeat (2) @(negedge clk); sclk = 0;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R6 tap in reset", tap_sel, hot(64));
    chk("R6 sdo in reset", 128'(sdo_pull_low), 128'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R6 tap after reset", tap_sel, hot(64));
    chk("R6 switches after reset", {126'd0, sw_a_closed, sw_b_closed}, 128'b10);

    send(7'h2D, 7);
    chk("R1 R2 word 0x2D", tap_sel, hot(45));
    send(7'h00, 7);
    chk("R10 code 0x00", tap_sel, hot(0));
    send(7'h7F, 7);
    chk("R10 code 0x7F", tap_sel, hot(127));

    send(10'b1110010011, 10);
    chk("R4 last seven bits", tap_sel, hot(7'h13));

    idle_clocks();
    chk("R3 clocks while deselected", tap_sel, hot(7'h13));

    // R11 latency
    @(negedge clk) cs_n = 0;
    for (int i = 6; i >= 0; i--) begin
      sdi = (7'h55 >> i) & 1;
      repeat (2) @(negedge clk); sclk = 1;
      repeat (2) @(negedge clk); sclk = 0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (3) @(negedge clk);
    chk("R11 old tap after third edge", tap_sel, hot(7'h13));
    @(negedge clk);
    chk("R11 new tap after fourth edge", tap_sel, hot(7'h55));
    repeat (4) @(negedge clk);

    // R5 chained frame: first seven 0101010, last seven 0010101
    send({7'b0101010, 7'h15}, 14);
    chk("R4 chained near code", tap_sel, hot(7'h15));
    chk("R5 sdo shows seventh bit", 128'(sdo_pull_low), 128'd1);

    shdn_n = 0;
    repeat (5) @(negedge clk);
    chk("R7 tap off in shutdown", tap_sel, 128'd0);
    chk("R7 switches in shutdown", {126'd0, sw_a_closed, sw_b_closed}, 128'b01);
    chk("R7 sdo released", 128'(sdo_pull_low), 128'd0);
    shdn_n = 1;
    repeat (5) @(negedge clk);
    chk("R8 restore after shutdown", tap_sel, hot(7'h15));

    shdn_n = 0;
    send(7'h11, 7);
    chk("R9 write during shutdown hidden", tap_sel, 128'd0);
    shdn_n = 1;
    repeat (5) @(negedge clk);
    chk("R9 preset applied", tap_sel, hot(7'h11));

    rst_n = 0;
    @(negedge clk);
    chk("R6 reset mid-run", tap_sel, hot(64));
    chk("R6 sdo latch cleared", 128'(sdo_pull_low), 128'd0);
    rst_n = 1;
    send(7'h3A, 7);
    chk("R2 load after reset", tap_sel, hot(7'h3A));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule